// File: doc/BRIEF.md
# NCO-Driven Digital Mixer

This block multiplies a stream of signed samples by a locally generated cosine. One datapath serves for up-conversion, where a baseband sample is placed onto a carrier, and for down-conversion, where a carrier-rate signal is brought back to baseband. The local oscillator is a numerically controlled oscillator. A phase accumulator advances by a programmable frequency word on every clock. An unrolled, pipelined CORDIC rotator turns that phase into a cosine whose peak equals a programmable amplitude.

Samples arrive at a lower rate than the mixer clock. A valid strobe marks each new sample, and the block holds the last accepted sample between strobes. The multiplier has a register on each of its inputs and one on its product, so that it maps onto a hard DSP multiplier. A runtime enable stops the oscillator phase and drives the mixed output to zero.

Top module: `ncoMixer`

## Requirements
- R1: While `enable` is high, the phase advances by `freqWord` on every rising edge, modulo 2^PHASE_W. The carrier frequency is therefore fclk·freqWord/2^PHASE_W. With freqWord = 2^PHASE_W/8 and a held sample, the output repeats exactly every 8 cycles, and samples 4 cycles apart are negatives of each other.
- R2: The oscillator value is ampWord·cos(2π·phase/2^PHASE_W) to within 3 LSB. `ampWord` is unsigned, ranges from 0 to 2^(OSC_W-1)-1 and sets the peak directly. An amplitude of 0 yields a zero output.
- R3: The mixed output is the held sample times the oscillator value, divided by 2^(OSC_W-1) and rounded toward minus infinity. It lies within 4 LSB of the ideal real product, keeps the correct sign for both signs of sample and cosine, and does not wrap at full-scale inputs.
- R4: `sampleIn` is captured only on a rising edge where `sampleValid` is high. Between strobes, changes on `sampleIn` have no effect on the output. A strobe on every second clock carries the most recent strobed value through.
- R5: A newly strobed sample first appears at `mixOut` on the third rising edge, counting the edge that captures it. The output after the first and second of those edges still reflects the previous sample.
- R6: With `enable` low, `mixOut` is zero after the next rising edge and stays zero for as long as `enable` stays low.
- R7: While `enable` is low the phase holds, whatever the value of `freqWord`. On re-enable with a zero frequency word, the output settles to exactly the value it had before the block was disabled.
- R8: All four quadrants of the phase circle give the correct cosine sign and magnitude. Before rotation, the angle is folded into the range of ±90 degrees.
- R9: While reset (`rstN` low) is asserted, and straight after it, `mixOut` is zero and the phase is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Mixer clock |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the oscillator; when low, the output is zero and the phase holds |
| freqWord | input | PHASE_W | Phase increment per clock |
| ampWord | input | OSC_W-1 | Oscillator peak amplitude, unsigned |
| sampleIn | input | DATA_W | Signed input sample |
| sampleValid | input | 1 | Strobe that accepts `sampleIn` |
| mixOut | output | DATA_W | Signed mixed sample |

## Verification
The phase is stepped by known amounts and then frozen with a zero frequency word. Each settled output can then be compared with a real-valued cosine product. A table of such steps covers every quadrant, a negative frequency word, zero and full-scale amplitudes, and both signs of full-scale samples, which separates sign, magnitude and fold errors. A free-running eighth-of-a-turn word exposes period and half-period symmetry, which a wrong accumulator or carrier sign would break. Directed sequences then measure the exact three-edge sample latency, try sample changes without a strobe and with a strobe on alternate cycles, and disable the block under a nonzero frequency word to show that the output is zeroed and the phase is held.

// File: rtl/mixPkg.sv
package mixPkg;

  typedef struct packed {
    logic takeSample;
    logic oscOn;
  } mixStrobe_t;

  // arctan(2^-idx) as a fraction of a full turn, scaled by 2^32
  function automatic longint atanTurn32(input int idx);
    case (idx)
      0:  return 64'd536870912;
      1:  return 64'd316933406;
      2:  return 64'd167458907;
      3:  return 64'd85004756;
      4:  return 64'd42667331;
      5:  return 64'd21354465;
      6:  return 64'd10679838;
      7:  return 64'd5340245;
      8:  return 64'd2670163;
      9:  return 64'd1335087;
      10: return 64'd667544;
      11: return 64'd333772;
      default: return 64'd683565276 >> idx;
    endcase
  endfunction

endpackage

// File: rtl/mixCordic.sv
module mixCordic #(
  parameter int PHASE_W = 16,
  parameter int OSC_W   = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PHASE_W-1:0]      phaseIn,
  input  logic [OSC_W-2:0]        ampIn,
  output logic signed [OSC_W-1:0] cosOut
);
  import mixPkg::*;

  localparam int GUARD  = 2;
  localparam int ITER   = OSC_W;
  localparam int CW     = OSC_W + GUARD + 1;
  localparam int ZW     = PHASE_W + 1;
  localparam int KSHIFT = 16;
  localparam int KGAIN  = 39797;              // 1/1.64676 in Q16
  localparam int PKW    = OSC_W - 1 + GUARD + KSHIFT;
  localparam logic signed [ZW-1:0] QPOS   = ZW'(1 << (PHASE_W - 2));
  localparam logic signed [ZW-1:0] QNEG   = -QPOS;
  localparam logic signed [CW-1:0] ROUNDC = CW'(1 << (GUARD - 1));
  localparam logic signed [CW-1:0] OMAX   = CW'((1 << (OSC_W - 1)) - 1);
  localparam logic signed [CW-1:0] OMIN   = -OMAX;
  localparam longint HALFLSB = 64'sd1 <<< (31 - PHASE_W);

  logic signed [CW-1:0] xS [ITER+1];
  logic signed [CW-1:0] yS [ITER+1];
  logic signed [ZW-1:0] zS [ITER];
  logic                 negS [ITER+1];

  // quadrant fold: the second and third quadrants get a half turn and a sign flip
  logic [1:0]           quad;
  logic                 flip;
  logic [PHASE_W-1:0]   rot;
  logic [PKW-1:0]       prodK;
  logic signed [CW-1:0] xInit;

  always_comb begin
    quad  = phaseIn[PHASE_W-1:PHASE_W-2];
    flip  = (quad == 2'b01) || (quad == 2'b10);
    rot   = flip ? {~phaseIn[PHASE_W-1], phaseIn[PHASE_W-2:0]} : phaseIn;
    prodK = (PKW'(ampIn) << GUARD) * PKW'(KGAIN);
    xInit = CW'(prodK >> KSHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xS[0]   <= '0;
      yS[0]   <= '0;
      zS[0]   <= '0;
      negS[0] <= 1'b0;
    end else begin
      xS[0]   <= xInit;
      yS[0]   <= '0;
      zS[0]   <= {rot[PHASE_W-1], rot};
      negS[0] <= flip;
    end
  end

  for (genvar i = 0; i < ITER; i++) begin : g_stage
    localparam longint ANGW = (atanTurn32(i) + HALFLSB) >> (32 - PHASE_W);
    localparam logic signed [ZW-1:0] ANG = ZW'(ANGW);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        xS[i+1]   <= '0;
        yS[i+1]   <= '0;
        negS[i+1] <= 1'b0;
      end else begin
        negS[i+1] <= negS[i];
        if (!zS[i][ZW-1]) begin
          xS[i+1] <= xS[i] - (yS[i] >>> i);
          yS[i+1] <= yS[i] + (xS[i] >>> i);
        end else begin
          xS[i+1] <= xS[i] + (yS[i] >>> i);
          yS[i+1] <= yS[i] - (xS[i] >>> i);
        end
      end
    end

    if (i < ITER - 1) begin : g_z
      always_ff @(posedge clk) begin
        if (!rstN) zS[i+1] <= '0;
        else       zS[i+1] <= zS[i][ZW-1] ? zS[i] + ANG : zS[i] - ANG;
      end
    end
  end

  logic signed [CW-1:0] xRnd, xSgn, oscNext;
  always_comb begin
    xRnd = (xS[ITER] + ROUNDC) >>> GUARD;
    xSgn = negS[ITER] ? -xRnd : xRnd;
    if (xSgn > OMAX)      oscNext = OMAX;
    else if (xSgn < OMIN) oscNext = OMIN;
    else                  oscNext = xSgn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cosOut <= '0;
    else       cosOut <= oscNext[OSC_W-1:0];
  end

  // R8: the folded angle entering the rotator stays within a quarter turn
  assert_fold_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (zS[0] <= QPOS) && (zS[0] >= QNEG));

endmodule

// File: rtl/mixCtrl.sv
module mixCtrl #(
  parameter int PHASE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic [PHASE_W-1:0]  freqWord,
  input  logic                sampleValid,
  output logic [PHASE_W-1:0]  phaseAcc,
  output mixPkg::mixStrobe_t  strobe
);
  import mixPkg::*;

  always_comb begin
    strobe.takeSample = sampleValid;
    strobe.oscOn      = enable;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       phaseAcc <= '0;
    else if (enable) phaseAcc <= phaseAcc + freqWord;
  end

  // R7: phase frozen while the oscillator is off
  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> phaseAcc == $past(phaseAcc));

endmodule

// File: rtl/mixDatapath.sv
module mixDatapath #(
  parameter int PHASE_W = 16,
  parameter int DATA_W  = 12,
  parameter int OSC_W   = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mixPkg::mixStrobe_t       strobe,
  input  logic [PHASE_W-1:0]       phaseAcc,
  input  logic [OSC_W-2:0]         ampWord,
  input  logic signed [DATA_W-1:0] sampleIn,
  output logic signed [DATA_W-1:0] mixOut
);
  import mixPkg::*;

  localparam int PW = DATA_W + OSC_W;

  logic signed [OSC_W-1:0]  oscVal;
  logic signed [DATA_W-1:0] sampleReg;
  logic signed [PW-1:0]     prodReg;

  mixCordic #(.PHASE_W(PHASE_W), .OSC_W(OSC_W)) u_cordic (
    .clk     (clk),
    .rstN    (rstN),
    .phaseIn (phaseAcc),
    .ampIn   (ampWord),
    .cosOut  (oscVal)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleReg <= '0;
      prodReg   <= '0;
      mixOut    <= '0;
    end else begin
      if (strobe.takeSample) sampleReg <= sampleIn;
      prodReg <= sampleReg * oscVal;
      mixOut  <= strobe.oscOn ? DATA_W'(prodReg >>> (OSC_W - 1)) : '0;
    end
  end

  // R4: the held sample only moves on a strobe
  assert_sample_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeSample |=> $stable(sampleReg));

  // R6: output silenced one edge after the enable drops
  assert_zero_when_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.oscOn |=> mixOut == '0);

endmodule

// File: rtl/ncoMixer.sv
module ncoMixer #(
  parameter int PHASE_W = 16,
  parameter int DATA_W  = 12,
  parameter int OSC_W   = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enable,
  input  logic [PHASE_W-1:0]       freqWord,
  input  logic [OSC_W-2:0]         ampWord,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic                     sampleValid,
  output logic signed [DATA_W-1:0] mixOut
);
  import mixPkg::*;

  mixStrobe_t         strobe;
  logic [PHASE_W-1:0] phaseAcc;

  mixCtrl #(.PHASE_W(PHASE_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .freqWord    (freqWord),
    .sampleValid (sampleValid),
    .phaseAcc    (phaseAcc),
    .strobe      (strobe)
  );

  mixDatapath #(.PHASE_W(PHASE_W), .DATA_W(DATA_W), .OSC_W(OSC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .phaseAcc (phaseAcc),
    .ampWord  (ampWord),
    .sampleIn (sampleIn),
    .mixOut   (mixOut)
  );

  // R9: output quiet whenever reset was applied on the previous edge
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> mixOut == '0);

endmodule

// File: tb/ncoMixer_tb.sv
`timescale 1ns/1ps
module ncoMixer_tb;
  localparam int PHASE_W = 16;
  localparam int DATA_W  = 12;
  localparam int OSC_W   = 12;
  localparam int TURN    = 1 << PHASE_W;
  localparam real PI     = 3.14159265358979;
  localparam real SCALE  = 2048.0;
  localparam int SETTLE  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [PHASE_W-1:0] freqWord = '0;
  logic [OSC_W-2:0] ampWord = '0;
  logic signed [DATA_W-1:0] sampleIn = '0;
  logic sampleValid = 1'b0;
  logic signed [DATA_W-1:0] mixOut;

  int checks = 0;
  int errors = 0;
  int phaseModel = 0;

  always #2 clk = ~clk;

  ncoMixer #(.PHASE_W(PHASE_W), .DATA_W(DATA_W), .OSC_W(OSC_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .freqWord(freqWord),
    .ampWord(ampWord), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .mixOut(mixOut)
  );

  // steps, frequency word, amplitude, sample
  localparam int NV = 8;
  localparam int vSteps [NV] = '{0, 4, 1, 3, 2, 5, 0, 7};
  localparam int vFreq  [NV] = '{0, 4096, 16384, 2731, 12000, 65000, 0, 777};
  localparam int vAmp   [NV] = '{2047, 2047, 1024, 2000, 1500, 700, 0, 2047};
  localparam int vSamp  [NV] = '{1000, 1500, -1200, 800, -2048, 2047, 2000, -2048};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic real idealMix(input int s, input int a, input int ph);
    return s * a * $cos(2.0 * PI * ph / TURN) / SCALE;
  endfunction

  task automatic checkNear(input string req, input int act, input real exp, input real tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0.2f", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic advance(input int f, input int n);
    freqWord = PHASE_W'(f);
    tick(n);
    freqWord = '0;
    phaseModel = (phaseModel + (n * f) % TURN) % TURN;
  endtask

  task automatic strobeSample(input int s);
    sampleIn = DATA_W'(s);
    sampleValid = 1'b1;
    tick(1);
    sampleValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int arr [16];
    int saved;
    int s;
    real energy;
    tick(3);
    checkEq("R9 output in reset", int'(mixOut), 0);
    rstN = 1'b1;
    tick(1);
    checkEq("R9 output after reset", int'(mixOut), 0);
    enable = 1'b1;

    // table walk: freeze the phase at known points and compare settled products
    for (int v = 0; v < NV; v++) begin
      ampWord = OSC_W'(vAmp[v]) - 1'b0 == 0 ? '0 : (OSC_W-1)'(vAmp[v]);
      strobeSample(vSamp[v]);
      advance(vFreq[v], vSteps[v]);
      tick(SETTLE);
      checkNear($sformatf("R2 R3 R8 vector %0d", v), int'(mixOut),
                idealMix(vSamp[v], vAmp[v], phaseModel), 4.0);
    end

    // R1: eighth-turn word gives period 8 and half-period sign flip
    ampWord = (OSC_W-1)'(2047);
    strobeSample(1500);
    freqWord = PHASE_W'(TURN / 8);
    tick(SETTLE);
    for (int k = 0; k < 16; k++) begin
      arr[k] = int'(mixOut);
      tick(1);
    end
    freqWord = '0;
    phaseModel = (phaseModel + ((SETTLE + 16) * (TURN / 8)) % TURN) % TURN;
    energy = 0.0;
    for (int k = 0; k < 8; k++) begin
      checkEq("R1 period of eight", arr[k + 8], arr[k]);
      checkNear("R1 half period negation", arr[k + 4], -arr[k], 6.0);
      energy += arr[k] * arr[k];
    end
    checkNear("R1 carrier power", int'(energy / 1000.0),
              8.0 * (1500.0 * 2047.0 / SCALE) ** 2 / 2.0 / 1000.0, 400.0);

    // R5: bring phase to zero, then time a new sample through the pipeline
    advance((TURN - phaseModel) % TURN, 1);
    strobeSample(500);
    tick(SETTLE);
    checkNear("R5 baseline", int'(mixOut), idealMix(500, 2047, 0), 4.0);
    saved = int'(mixOut);
    sampleIn = -12'sd900;
    sampleValid = 1'b1;
    tick(1);
    sampleValid = 1'b0;
    checkEq("R5 unchanged after capture edge", int'(mixOut), saved);
    tick(1);
    checkEq("R5 unchanged after second edge", int'(mixOut), saved);
    tick(1);
    checkNear("R5 new sample on third edge", int'(mixOut), idealMix(-900, 2047, 0), 4.0);

    // R4: sample changes without a strobe are ignored
    saved = int'(mixOut);
    for (int k = 0; k < 6; k++) begin
      sampleIn = DATA_W'(1777 - 611 * k);
      tick(1);
    end
    checkEq("R4 no strobe no change", int'(mixOut), saved);

    // R4: strobe on every second clock, sample moving every clock
    for (int k = 0; k < 8; k++) begin
      s = 100 * k - 300;
      sampleIn = DATA_W'(s);
      sampleValid = (k % 2 == 0);
      tick(1);
    end
    sampleValid = 1'b0;
    tick(5);
    checkNear("R4 alternate strobes keep last strobed", int'(mixOut), idealMix(300, 2047, 0), 4.0);

    // R6 and R7: disable with a live frequency word, then re-enable
    saved = int'(mixOut);
    enable = 1'b0;
    freqWord = PHASE_W'(5000);
    tick(1);
    checkEq("R6 zero one edge after disable", int'(mixOut), 0);
    tick(5);
    checkEq("R6 zero while disabled", int'(mixOut), 0);
    freqWord = '0;
    enable = 1'b1;
    tick(SETTLE);
    checkEq("R7 phase held across disable", int'(mixOut), saved);

    // R9: reset again mid-run
    rstN = 1'b0;
    tick(1);
    checkEq("R9 output after late reset", int'(mixOut), 0);
    rstN = 1'b1;
    tick(SETTLE);
    checkNear("R9 phase restarts at zero", int'(mixOut), 0.0, 0.0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule